// File: doc/BRIEF.md
# HDLC Receive Frame Status Unit

This unit sits behind the line interface of a bit-serial HDLC receiver on an ISDN D channel. It takes the raw receive bit stream, one bit per strobe, and does three things with it. It finds the 0x7E delimiters. It strips stuffed zeros. It packs the payload into bytes and offers each one on a write strobe to an external receive FIFO. Every byte that reaches the FIFO, including the two frame check bytes, also passes through a CRC-16 checker.

The unit keeps a status byte with three fields: data overflow, CRC error and message abort. A closing delimiter or an abort sequence ends the frame and raises a level end-of-message interrupt. From that point the receiver is parked, so the status stays frozen until software acknowledges the frame. An overflow raises its own interrupt but does not stop reception, so incoming bytes keep overwriting the FIFO. An abort leaves the receiver dead until a receiver-reset command. That command also clears the sticky overflow and restarts flag hunting.

Top module: `hdlc_rx_status`

## Requirements
- R1: After the synchronous reset, and after a receiver-reset command, the status byte reads 0x20, both interrupts are low and no FIFO write is issued.
- R2: Any 0 that follows five consecutive 1s is removed. Bits are packed least significant bit first. Every completed byte between an opening and a closing 0x7E, the two check bytes included, produces exactly one `fifo_wr` pulse carrying that byte.
- R3: The status byte uses bit 6 for data overflow, bit 5 for CRC error and bit 4 for message abort; all other bits read 0. At a closing flag, bit 5 becomes 0 only if the CRC-16 (polynomial x^16+x^12+x^5+1, preset all ones, bits taken in line order) over data plus check bytes leaves the residue 0xF0B8 on a byte boundary, and it becomes 1 otherwise.
- R4: Seven consecutive 1s inside a frame set bit 4 and raise `irq_eom`. After that, no FIFO write occurs and the status does not change, even across acknowledges and later valid frames, until a receiver reset.
- R5: A FIFO write issued while `fifo_full` is high sets bit 6 and raises `irq_ovf`, and reception and writing continue. The overflow bit stays set until a receiver reset. The frame-count limit of the FIFO has no input here and cannot set it.
- R6: From the end-of-message event until `cmd_ack`, the status byte is stable and any further line traffic causes no FIFO write.
- R7: `cmd_ack` drops both interrupts and re-arms flag hunting after a completed frame.
- R8: Back-to-back flags, before a frame or after an opening flag, do not end a frame or raise an interrupt.
- R9: The interrupts are levels that stay high until acknowledge or receiver reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Receive line bit |
| rx_bit_vld | input | 1 | Strobe marking `rx_bit` valid for this cycle |
| fifo_full | input | 1 | Receive FIFO is full |
| fifo_wr | output | 1 | Write strobe for one received byte |
| fifo_wdata | output | 8 | Received byte |
| cmd_ack | input | 1 | Frame acknowledge command, one-cycle pulse |
| cmd_rrst | input | 1 | Receiver reset command, one-cycle pulse |
| status | output | 8 | Status byte: bit 6 overflow, bit 5 CRC error, bit 4 abort |
| irq_eom | output | 1 | End-of-message interrupt, level |
| irq_ovf | output | 1 | Data-overflow interrupt, level |

## Verification
The bench sends frames of random length and content, some with one flipped bit, with idle gaps in the bit strobe. This separates a CRC that is correct from one that only tracks lengths, and separates byte packing from gap handling. Fixed payloads packed with 0x7E and 0xFF bytes force heavy stuffing, which exposes destuffing and flag-filtering faults that random data rarely hits. Frames sent while the receiver is parked or aborted show whether the freeze and the abort lockout hold. Overflowed frames show that the writes carry on while the overflow bit sticks.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,  // looking for an opening delimiter
    ST_OPEN  = 2'd1,  // collecting frame bits
    ST_HOLD  = 2'd2,  // frame ended, waiting for acknowledge
    ST_ABORT = 2'd3   // aborted, waiting for receiver reset
  } rx_state_e;

  localparam int STAT_OVF_BIT = 6;
  localparam int STAT_CRC_BIT = 5;
  localparam int STAT_ABT_BIT = 4;

endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int BYTE_W = 8,  // must be a power of two
  parameter int RUN    = 5   // ones before a stuffed zero
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              collect,
  input  logic              bit_in,
  input  logic              bit_vld,
  output logic              flag_ev,
  output logic              abort_ev,
  output logic              pop_vld,
  output logic              pop_bit,
  output logic              data_seen,
  output logic              aligned,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int DLY    = RUN + 1;           // delimiter bits that reach the data path
  localparam int CNT_W  = $clog2(RUN + 3);
  localparam int FILL_W = $clog2(DLY + 1);
  localparam int PH_W   = $clog2(BYTE_W);

  logic [CNT_W-1:0]  ones_q;
  logic [DLY-1:0]    dly_q;
  logic [FILL_W-1:0] fill_q;
  logic [BYTE_W-1:0] sr_q;
  logic [PH_W-1:0]   ph_q;
  logic              push;
  logic              restart;

  // Line events are decoded from the run of ones seen so far.
  assign flag_ev  = bit_vld && !bit_in && (ones_q == CNT_W'(RUN + 1));
  assign abort_ev = bit_vld &&  bit_in && (ones_q == CNT_W'(RUN + 1));
  assign push     = bit_vld && collect && (ones_q < CNT_W'(RUN));
  assign pop_vld  = push && (fill_q == FILL_W'(DLY));
  assign pop_bit  = dly_q[DLY-1];
  assign aligned  = (ph_q == '0);
  assign restart  = clr || flag_ev || abort_ev;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ones_q <= '0;
    end else if (bit_vld) begin
      if (!bit_in)                           ones_q <= '0;
      else if (ones_q != CNT_W'(RUN + 2))    ones_q <= ones_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      fill_q    <= '0;
      ph_q      <= '0;
      data_seen <= 1'b0;
      wr_en     <= 1'b0;
      dly_q     <= '0;
      sr_q      <= '0;
    end else begin
      wr_en <= 1'b0;
      if (push) begin
        dly_q <= {dly_q[DLY-2:0], bit_in};
        if (fill_q != FILL_W'(DLY)) fill_q <= fill_q + 1'b1;
      end
      if (pop_vld) begin
        sr_q      <= {pop_bit, sr_q[BYTE_W-1:1]};
        ph_q      <= ph_q + 1'b1;
        data_seen <= 1'b1;
        if (ph_q == PH_W'(BYTE_W - 1)) begin
          wr_en   <= 1'b1;
          wr_data <= {pop_bit, sr_q[BYTE_W-1:1]};
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h8408,  // reflected generator
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         en,
  input  logic         d,
  output logic [W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || init)
      crc <= INIT;
    else if (en)
      crc <= (crc >> 1) ^ ((crc[0] ^ d) ? POLY : '0);
  end
endmodule

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int              CRC_W       = 16,
  parameter logic [CRC_W-1:0] CRC_RESIDUE = 16'hF0B8,
  parameter int              STAT_W      = 8,
  parameter logic [STAT_W-1:0] STAT_RESET = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_ack,
  input  logic              cmd_rrst,
  input  logic              flag_ev,
  input  logic              abort_ev,
  input  logic              data_seen,
  input  logic              aligned,
  input  logic [CRC_W-1:0]  crc,
  input  logic              wr_en,
  input  logic              fifo_full,
  output logic              collect,
  output logic [STAT_W-1:0] status,
  output logic              irq_eom,
  output logic              irq_ovf
);
  rx_state_e state_q;
  logic      ovf_q, crc_err_q, abt_q;

  assign collect = (state_q == ST_OPEN);

  always_comb begin
    status               = '0;
    status[STAT_OVF_BIT] = ovf_q;
    status[STAT_CRC_BIT] = crc_err_q;
    status[STAT_ABT_BIT] = abt_q;
  end

  always_ff @(posedge clk) begin
    if (rst || cmd_rrst) begin
      state_q   <= ST_HUNT;
      ovf_q     <= STAT_RESET[STAT_OVF_BIT];
      crc_err_q <= STAT_RESET[STAT_CRC_BIT];
      abt_q     <= STAT_RESET[STAT_ABT_BIT];
      irq_eom   <= 1'b0;
      irq_ovf   <= 1'b0;
    end else begin
      case (state_q)
        ST_HUNT: if (flag_ev) state_q <= ST_OPEN;
        ST_OPEN: begin
          if (abort_ev) begin
            state_q <= ST_ABORT;
            abt_q   <= 1'b1;
            irq_eom <= 1'b1;
          end else if (flag_ev && data_seen) begin
            state_q   <= ST_HOLD;
            crc_err_q <= !(aligned && (crc == CRC_RESIDUE));
            abt_q     <= 1'b0;
            irq_eom   <= 1'b1;
          end
        end
        ST_HOLD: if (cmd_ack) begin
          state_q <= ST_HUNT;
          irq_eom <= 1'b0;
        end
        ST_ABORT: if (cmd_ack) irq_eom <= 1'b0;
        default: state_q <= ST_HUNT;
      endcase
      if (cmd_ack) irq_ovf <= 1'b0;
      if (wr_en && fifo_full) begin
        ovf_q   <= 1'b1;
        irq_ovf <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status #(
  parameter int                BYTE_W      = 8,
  parameter int                STUFF_RUN   = 5,
  parameter int                CRC_W       = 16,
  parameter logic [CRC_W-1:0]  CRC_POLY    = 16'h8408,
  parameter logic [CRC_W-1:0]  CRC_RESIDUE = 16'hF0B8,
  parameter int                STAT_W      = 8,
  parameter logic [STAT_W-1:0] STAT_RESET  = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit,
  input  logic              rx_bit_vld,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [BYTE_W-1:0] fifo_wdata,
  input  logic              cmd_ack,
  input  logic              cmd_rrst,
  output logic [STAT_W-1:0] status,
  output logic              irq_eom,
  output logic              irq_ovf
);
  logic             collect, flag_ev, abort_ev, pop_vld, pop_bit;
  logic             data_seen, aligned;
  logic [CRC_W-1:0] crc;

  hdlc_rx_deframer #(.BYTE_W(BYTE_W), .RUN(STUFF_RUN)) u_deframer (
    .clk       (clk),
    .rst       (rst),
    .clr       (cmd_rrst),
    .collect   (collect),
    .bit_in    (rx_bit),
    .bit_vld   (rx_bit_vld),
    .flag_ev   (flag_ev),
    .abort_ev  (abort_ev),
    .pop_vld   (pop_vld),
    .pop_bit   (pop_bit),
    .data_seen (data_seen),
    .aligned   (aligned),
    .wr_en     (fifo_wr),
    .wr_data   (fifo_wdata)
  );

  hdlc_rx_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk  (clk),
    .rst  (rst),
    .init (flag_ev || abort_ev || cmd_rrst),
    .en   (pop_vld),
    .d    (pop_bit),
    .crc  (crc)
  );

  hdlc_rx_ctrl #(
    .CRC_W(CRC_W), .CRC_RESIDUE(CRC_RESIDUE),
    .STAT_W(STAT_W), .STAT_RESET(STAT_RESET)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_ack   (cmd_ack),
    .cmd_rrst  (cmd_rrst),
    .flag_ev   (flag_ev),
    .abort_ev  (abort_ev),
    .data_seen (data_seen),
    .aligned   (aligned),
    .crc       (crc),
    .wr_en     (fifo_wr),
    .fifo_full (fifo_full),
    .collect   (collect),
    .status    (status),
    .irq_eom   (irq_eom),
    .irq_ovf   (irq_ovf)
  );

endmodule

// File: rtl/hdlc_rx_status_chk.sv
module hdlc_rx_status_chk #(
  parameter int                STAT_W     = 8,
  parameter logic [STAT_W-1:0] STAT_RESET = 8'h20
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_ack,
  input logic              cmd_rrst,
  input logic              fifo_full,
  input logic              fifo_wr,
  input logic [STAT_W-1:0] status,
  input logic              irq_eom,
  input logic              irq_ovf
);
  // R1
  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> (status == STAT_RESET && !irq_eom && !irq_ovf && !fifo_wr));

  // R5
  a_r5_overflow_flags: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr && fifo_full && !cmd_rrst) |=> (status[6] && irq_ovf));

  // R6, R9
  a_r6_status_frozen: assert property (@(posedge clk) disable iff (rst)
    (irq_eom && !cmd_ack && !cmd_rrst) |=> ($stable(status) && irq_eom));

  // R4
  a_r4_abort_blocks_writes: assert property (@(posedge clk) disable iff (rst)
    status[4] |-> !fifo_wr);

  // R7
  a_r7_rrst_restores: assert property (@(posedge clk) disable iff (rst)
    cmd_rrst |=> (status == STAT_RESET && !irq_eom && !irq_ovf));

  // R3
  a_r3_spare_bits_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_eom) |-> ((status & 8'h8F) == 8'h00));
endmodule

bind hdlc_rx_status hdlc_rx_status_chk #(.STAT_W(STAT_W), .STAT_RESET(STAT_RESET)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_ack   (cmd_ack),
  .cmd_rrst  (cmd_rrst),
  .fifo_full (fifo_full),
  .fifo_wr   (fifo_wr),
  .status    (status),
  .irq_eom   (irq_eom),
  .irq_ovf   (irq_ovf)
);

// File: tb/hdlc_rx_status_test.sv
`timescale 1ns/1ps
module hdlc_rx_status_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b1, rx_bit_vld = 1'b0, fifo_full = 1'b0;
  logic       cmd_ack = 1'b0, cmd_rrst = 1'b0;
  logic       fifo_wr;
  logic [7:0] fifo_wdata, status;
  logic       irq_eom, irq_ovf;

  int tests = 0, fails = 0, nwr = 0;
  bit done = 1'b0, gaps = 1'b0;
  logic [7:0] snd [0:21];
  logic [7:0] got [0:63];
  int nsnd = 0;

  always #2 clk = ~clk;

  hdlc_rx_status uut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .cmd_ack(cmd_ack), .cmd_rrst(cmd_rrst), .status(status),
    .irq_eom(irq_eom), .irq_ovf(irq_ovf)
  );

  always @(negedge clk) if (fifo_wr) begin
    if (nwr < 64) got[nwr] = fifo_wdata;
    nwr++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] b);
    for (int i = 0; i < 8; i++)
      c = (c >> 1) ^ ((c[0] ^ b[i]) ? 16'h8408 : 16'h0000);
    return c;
  endfunction

  function automatic logic [7:0] exp_stat(bit ovf, bit crc, bit abt);
    return {1'b0, ovf, crc, abt, 4'b0000};
  endfunction

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_raw(bit b);
    if (gaps && $urandom_range(0, 5) == 0) begin
      rx_bit_vld = 1'b0;
      @(negedge clk);
    end
    rx_bit = b;
    rx_bit_vld = 1'b1;
    @(negedge clk);
    rx_bit_vld = 1'b0;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_raw(8'h7E >> i);
  endtask

  task automatic send_stuffed(logic [7:0] b, inout int ones);
    for (int i = 0; i < 8; i++) begin
      send_raw(b[i]);
      ones = b[i] ? ones + 1 : 0;
      if (ones == 5) begin
        send_raw(1'b0);
        ones = 0;
      end
    end
  endtask

  // Builds FCS over snd[0:n-1], optionally flips one data bit, then sends.
  task automatic send_frame(int n, bit corrupt, int lead_flags = 1);
    logic [15:0] c = 16'hFFFF;
    int ones = 0;
    for (int i = 0; i < n; i++) c = crc_byte(c, snd[i]);
    c = ~c;
    snd[n] = c[7:0];
    snd[n+1] = c[15:8];
    nsnd = n + 2;
    if (corrupt) snd[$urandom_range(0, n - 1)] ^= 8'h08;
    nwr = 0;
    repeat (lead_flags) send_flag();
    for (int i = 0; i < nsnd; i++) send_stuffed(snd[i], ones);
    send_flag();
    tick(2);
  endtask

  task automatic chk_writes(string req);
    chk({req, " write count"}, nwr, nsnd);
    if (nwr == nsnd)
      for (int i = 0; i < nsnd; i++) chk({req, " byte"}, got[i], snd[i]);
  endtask

  task automatic pulse_ack();
    cmd_ack = 1'b1; tick(); cmd_ack = 1'b0;
  endtask

  task automatic pulse_rrst();
    cmd_rrst = 1'b1; tick(); cmd_rrst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    tick(4);
    rst = 1'b0;
    tick();
    // R1: reset state
    chk("R1 reset status", status, 8'h20);
    chk("R1 reset irqs", {irq_eom, irq_ovf}, 2'b00);
    chk("R1 no writes", nwr, 0);

    // Idle ones on the line while hunting have no effect
    for (int i = 0; i < 20; i++) send_raw(1'b1);
    chk("R8 idle ones", {status, irq_eom}, {8'h20, 1'b0});

    // R2/R3/R8: good frame after three back-to-back flags
    for (int i = 0; i < 4; i++) snd[i] = 8'h30 + 8'(i);
    send_frame(4, 1'b0, 3);
    chk_writes("R2 directed");
    chk("R3 good crc", status, exp_stat(0, 0, 0));
    chk("R9 eom raised", irq_eom, 1'b1);
    tick(5);
    chk("R9 eom level held", irq_eom, 1'b1);

    // R6: frame while parked is ignored
    for (int i = 0; i < 3; i++) snd[i] = 8'hA5;
    send_frame(3, 1'b1);
    chk("R6 no writes while held", nwr, 0);
    chk("R6 status frozen", status, exp_stat(0, 0, 0));

    // R7: ack drops interrupt and re-arms
    pulse_ack();
    chk("R7 ack clears eom", irq_eom, 1'b0);
    for (int i = 0; i < 5; i++) snd[i] = 8'(i * 37);
    send_frame(5, 1'b1);
    chk_writes("R2 corrupt frame");
    chk("R3 crc error", status, exp_stat(0, 1, 0));
    pulse_ack();

    // R2: heavy stuffing payload
    snd[0] = 8'h7E; snd[1] = 8'hFF; snd[2] = 8'hFF; snd[3] = 8'h7E; snd[4] = 8'h1F; snd[5] = 8'hF8;
    send_frame(6, 1'b0, 2);
    chk_writes("R2 stuffing");
    chk("R3 stuffing crc", status, exp_stat(0, 0, 0));
    pulse_ack();

    // R5: overflow keeps writing and sticks
    fifo_full = 1'b1;
    for (int i = 0; i < 6; i++) snd[i] = 8'(8'hC0 + i);
    send_frame(6, 1'b0);
    fifo_full = 1'b0;
    chk_writes("R5 writes continue");
    chk("R5 overflow status", status, exp_stat(1, 0, 0));
    chk("R5 overflow irq", irq_ovf, 1'b1);
    pulse_ack();
    chk("R7 ack clears ovf irq", {irq_ovf, irq_eom}, 2'b00);
    chk("R5 overflow sticky", status[6], 1'b1);
    pulse_rrst();
    chk("R1 rrst status", status, 8'h20);

    // R4: abort
    send_flag();
    send_raw(1'b0); send_raw(1'b1); send_raw(1'b0); send_raw(1'b0);
    for (int i = 0; i < 7; i++) send_raw(1'b1);
    send_raw(1'b0);
    tick(2);
    chk("R4 abort status", status, exp_stat(0, 1, 1));
    chk("R4 abort irq", irq_eom, 1'b1);
    pulse_ack();
    chk("R4 ack clears irq only", {status, irq_eom}, {exp_stat(0, 1, 1), 1'b0});
    for (int i = 0; i < 4; i++) snd[i] = 8'h5A;
    send_frame(4, 1'b0);
    chk("R4 no writes after abort", nwr, 0);
    chk("R4 status stays aborted", {status, irq_eom}, {exp_stat(0, 1, 1), 1'b0});
    pulse_rrst();
    chk("R7 rrst after abort", status, 8'h20);
    send_frame(4, 1'b0);
    chk_writes("R7 restart");
    chk("R7 restart status", status, exp_stat(0, 0, 0));
    pulse_ack();

    // Random frames with strobe gaps
    gaps = 1'b1;
    for (int k = 0; k < 16; k++) begin
      int  n   = $urandom_range(1, 16);
      bit  bad = $urandom_range(0, 1);
      bit  ful = ($urandom_range(0, 3) == 0);
      pulse_rrst();
      for (int i = 0; i < n; i++) snd[i] = 8'($urandom);
      fifo_full = ful;
      send_frame(n, bad, $urandom_range(1, 3));
      fifo_full = 1'b0;
      chk_writes("R2 random");
      chk("R3 random status", status, exp_stat(ful, bad, 0));
      chk("R5 random ovf irq", {irq_eom, irq_ovf}, {1'b1, ful});
      pulse_ack();
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule